// File: doc/BRIEF.md
# Reset-on-Read Framer Event Counters

This block holds the event counters of a T1/E1 framer's performance monitor. Two kinds of event arrive as single-cycle strobes. A strobe from the transmit slip buffer, which marks one frame repeated or one frame dropped, advances an 8-bit slip count. A strobe from the receive line, which marks an excessive-zero violation, advances a 16-bit violation count. Software reads the counts over a byte-wide read-only register bus. Every counter clears when it is read, so each value read is the number of events since the previous read.

The 16-bit count is read as two bytes, upper byte first. Reading the upper byte copies the whole count into a holding register and clears the live counter in the same cycle. The upper byte comes from that copy. The lower-byte read that follows returns the low half of the same copy, so both halves belong to one moment, even if events arrive between the two reads. Counters stop at all ones rather than wrapping. An event that lands in the same cycle as the clearing read is kept, and the counter restarts at one.

Top module: `perf_evt_counters`

## Requirements
- R1: After a synchronous active-high reset, all counters and the holding register are zero. Every read of address 0x090F, 0x0910 or 0x0911 then returns 0x00.
- R2: Each cycle with `slip_evt` high adds one to the slip count. A read at address 0x090F returns that count on `rd_data` in the cycle after `rd_en`.
- R3: A read at 0x090F clears the slip count, so an immediate second read returns 0x00.
- R4: A read at 0x0910 returns bits 15:8 of the violation count, copies all 16 bits into the holding register and clears the live count.
- R5: A read at 0x0911 returns bits 7:0 of the holding register. It leaves the live count unchanged, including when no upper-byte read came before it.
- R6: When an event strobe coincides with a read that clears that counter, the counter holds 1 after the read.
- R7: The slip count stops at 0xFF and the violation count stops at 0xFFFF. Further events leave the value unchanged.
- R8: A read of any other address returns 0x00 and changes no counter and no holding register. `rd_data` is 0x00 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slip_evt | input | 1 | One-cycle strobe for each transmit slip |
| zv_evt | input | 1 | One-cycle strobe for each receive excessive-zero violation |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 16 | Byte address of the read |
| rd_data | output | 8 | Read result, valid in the cycle after `rd_en` |

## Verification
Any fault in a live counter shows up at the next read of that counter. The read result appears on `rd_data` exactly one cycle after the strobe. A read that does not fully clear the counter shows as a nonzero value on the read that follows it. A snapshot taken at the wrong time, or a lower-byte read that clears the counter, only shows two accesses later. The bench therefore checks the 0x0911 result after a 0x0910 read, and checks a second upper/lower pair after that. The bench also checks the saturation limits at the exact counts, because an off-by-one error there is only visible after 255 or 65535 events.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SLIP_W = 8;
    localparam int ZV_W   = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] SLIP_ADDR  = 16'h090F;
    localparam logic [ADDR_W-1:0] ZV_HI_ADDR = 16'h0910;
    localparam logic [ADDR_W-1:0] ZV_LO_ADDR = 16'h0911;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SLIP,
        SEL_ZV_HI,
        SEL_ZV_LO
    } rd_sel_e;

    // One decoded access: which byte to return and which side effects to apply
    typedef struct packed {
        rd_sel_e sel;
        logic    clr_slip;
        logic    clr_zv;
        logic    cap_snap;
    } rd_ctl_t;

    function automatic logic [DATA_W-1:0] upper_byte(input logic [ZV_W-1:0] v);
        return v[ZV_W-1 -: DATA_W];
    endfunction

    function automatic logic [DATA_W-1:0] lower_byte(input logic [ZV_W-1:0] v);
        return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/pmon_sat_ctr.sv
module pmon_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP  = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            // a strobe in the clearing cycle becomes the first count of the new interval
            cnt <= inc ? ONE : '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/pmon_rd_decode.sv
module pmon_rd_decode
    import pmon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_SLIP  = SLIP_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_HI = ZV_HI_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_LO = ZV_LO_ADDR
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_ctl_t           ctl
);
    always_comb begin
        ctl = '{sel: SEL_NONE, clr_slip: 1'b0, clr_zv: 1'b0, cap_snap: 1'b0};
        if (rd_en) begin
            if (rd_addr == A_SLIP) begin
                ctl.sel      = SEL_SLIP;
                ctl.clr_slip = 1'b1;
            end else if (rd_addr == A_ZV_HI) begin
                ctl.sel      = SEL_ZV_HI;
                ctl.clr_zv   = 1'b1;
                ctl.cap_snap = 1'b1;
            end else if (rd_addr == A_ZV_LO) begin
                ctl.sel      = SEL_ZV_LO;
            end
        end
    end
endmodule

// File: rtl/perf_evt_counters.sv
module perf_evt_counters
    import pmon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_SLIP  = SLIP_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_HI = ZV_HI_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_LO = ZV_LO_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slip_evt,
    input  logic              zv_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    rd_ctl_t           ctl;
    logic [SLIP_W-1:0] slip_cnt;
    logic [ZV_W-1:0]   zv_cnt;
    logic [ZV_W-1:0]   zv_snap;
    logic [DATA_W-1:0] rd_next;

    pmon_rd_decode #(
        .A_SLIP  (A_SLIP),
        .A_ZV_HI (A_ZV_HI),
        .A_ZV_LO (A_ZV_LO)
    ) u_decode (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ctl     (ctl)
    );

    pmon_sat_ctr #(.W(SLIP_W)) u_slip_ctr (
        .clk (clk),
        .rst (rst),
        .inc (slip_evt),
        .clr (ctl.clr_slip),
        .cnt (slip_cnt)
    );

    pmon_sat_ctr #(.W(ZV_W)) u_zv_ctr (
        .clk (clk),
        .rst (rst),
        .inc (zv_evt),
        .clr (ctl.clr_zv),
        .cnt (zv_cnt)
    );

    // Holding register: loaded by the upper-byte read, feeds the lower-byte read
    always_ff @(posedge clk) begin
        if (rst) begin
            zv_snap <= '0;
        end else if (ctl.cap_snap) begin
            zv_snap <= zv_cnt;
        end
    end

    always_comb begin
        unique case (ctl.sel)
            SEL_SLIP:  rd_next = DATA_W'(slip_cnt);
            SEL_ZV_HI: rd_next = upper_byte(zv_cnt);
            SEL_ZV_LO: rd_next = lower_byte(zv_snap);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/perf_evt_counters_chk.sv
module perf_evt_counters_chk
    import pmon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_SLIP  = SLIP_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_HI = ZV_HI_ADDR,
    parameter logic [ADDR_W-1:0] A_ZV_LO = ZV_LO_ADDR
) (
    input logic              clk,
    input logic              rst,
    input logic              slip_evt,
    input logic              zv_evt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [SLIP_W-1:0] slip_cnt,
    input logic [ZV_W-1:0]   zv_cnt,
    input logic [ZV_W-1:0]   zv_snap
);
    localparam logic [SLIP_W-1:0] S_ONE = {{(SLIP_W-1){1'b0}}, 1'b1};
    localparam logic [SLIP_W-1:0] S_TOP = {SLIP_W{1'b1}};
    localparam logic [ZV_W-1:0]   Z_TOP = {ZV_W{1'b1}};

    logic rd_slip, rd_hi, rd_lo, rd_other;
    assign rd_slip  = rd_en && (rd_addr == A_SLIP);
    assign rd_hi    = rd_en && (rd_addr == A_ZV_HI);
    assign rd_lo    = rd_en && (rd_addr == A_ZV_LO);
    assign rd_other = rd_en && !rd_slip && !rd_hi && !rd_lo;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slip_cnt == '0 && zv_cnt == '0 && zv_snap == '0));

    assert_slip_step_R2: assert property (@(posedge clk) disable iff (rst)
        (slip_evt && !rd_slip && slip_cnt != S_TOP) |=> slip_cnt == $past(slip_cnt) + S_ONE);

    assert_slip_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_slip && !slip_evt) |=> slip_cnt == '0);

    assert_hi_capture_R4: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> (zv_snap == $past(zv_cnt) && rd_data == $past(zv_cnt[ZV_W-1 -: DATA_W])));

    assert_lo_keeps_count_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !zv_evt) |=> zv_cnt == $past(zv_cnt));

    assert_clear_with_event_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_slip && slip_evt) |=> slip_cnt == S_ONE);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (zv_cnt == Z_TOP && !rd_hi) |=> zv_cnt == Z_TOP);

    assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        rd_other |=> (rd_data == '0 && $stable(zv_snap)));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);
endmodule

bind perf_evt_counters perf_evt_counters_chk #(
    .A_SLIP  (A_SLIP),
    .A_ZV_HI (A_ZV_HI),
    .A_ZV_LO (A_ZV_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .slip_evt (slip_evt),
    .zv_evt   (zv_evt),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .slip_cnt (slip_cnt),
    .zv_cnt   (zv_cnt),
    .zv_snap  (zv_snap)
);

// File: tb/perf_evt_counters_bench.sv
`timescale 1ns/1ps
module perf_evt_counters_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slip_evt = 1'b0;
    logic        zv_evt = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = 16'h0000;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    perf_evt_counters u_perf_evt_counters (
        .clk      (clk),
        .rst      (rst),
        .slip_evt (slip_evt),
        .zv_evt   (zv_evt),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    typedef struct packed {
        logic        se;
        logic        ze;
        logic        re;
        logic [15:0] a;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 16'h090F, 8'h00, 4'd1},  // reset slip count
        '{1'b0, 1'b0, 1'b1, 16'h0910, 8'h00, 4'd1},  // reset violation count
        '{1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 4'd8},
        '{1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 4'd8},
        '{1'b1, 1'b1, 1'b0, 16'h0000, 8'h00, 4'd8},
        '{1'b0, 1'b0, 1'b1, 16'h090F, 8'h03, 4'd2},  // three slips
        '{1'b0, 1'b0, 1'b1, 16'h090F, 8'h00, 4'd3},  // cleared by read
        '{1'b0, 1'b1, 1'b0, 16'h0000, 8'h00, 4'd8},
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h00, 4'd5},  // lone low read: old snapshot
        '{1'b0, 1'b0, 1'b1, 16'h0910, 8'h00, 4'd4},  // snapshot = 2
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h02, 4'd5},
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h02, 4'd5},
        '{1'b0, 1'b0, 1'b1, 16'h0910, 8'h00, 4'd4},  // count was cleared
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h00, 4'd4},
        '{1'b1, 1'b0, 1'b1, 16'h090F, 8'h00, 4'd6},  // slip with clearing read
        '{1'b0, 1'b0, 1'b1, 16'h090F, 8'h01, 4'd6},
        '{1'b0, 1'b0, 1'b1, 16'h0912, 8'h00, 4'd8},
        '{1'b0, 1'b1, 1'b1, 16'h0000, 8'h00, 4'd8},
        '{1'b0, 1'b0, 1'b1, 16'h0910, 8'h00, 4'd8},  // snapshot = 1
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h01, 4'd8},
        '{1'b0, 1'b1, 1'b1, 16'h0910, 8'h00, 4'd6},  // violation with clearing read
        '{1'b0, 1'b0, 1'b1, 16'h0910, 8'h00, 4'd6},  // snapshot = 1
        '{1'b0, 1'b0, 1'b1, 16'h0911, 8'h01, 4'd6}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic se, input logic ze, input logic re, input logic [15:0] a);
        slip_evt = se;
        zv_evt   = ze;
        rd_en    = re;
        rd_addr  = a;
        @(negedge clk);
        slip_evt = 1'b0;
        zv_evt   = 1'b0;
        rd_en    = 1'b0;
        rd_addr  = 16'h0000;
    endtask

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%02h expected=%02h at %0t", req, rd_data, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(8'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].se, VECS[i].ze, VECS[i].re, VECS[i].a);
            check(VECS[i].exp, req_name(VECS[i].req));
        end

        // R4 / R5: a count whose upper byte is nonzero (300 = 0x012C)
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 1'b1, 16'h0910); check(8'h01, "R4");
        step(1'b0, 1'b0, 1'b1, 16'h0911); check(8'h2C, "R5");

        // R5: events between the two reads do not reach the low byte
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 1'b1, 16'h0910); check(8'h00, "R4");
        step(1'b0, 1'b1, 1'b1, 16'h0911); check(8'h05, "R5");
        step(1'b0, 1'b0, 1'b1, 16'h0910); check(8'h00, "R5");
        step(1'b0, 1'b0, 1'b1, 16'h0911); check(8'h01, "R5");

        // R7: slip count stops at 0xFF
        for (int i = 0; i < 260; i++) step(1'b1, 1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 1'b1, 16'h090F); check(8'hFF, "R7");
        step(1'b0, 1'b0, 1'b1, 16'h090F); check(8'h00, "R3");

        // R7: violation count stops at 0xFFFF
        for (int i = 0; i < 65540; i++) step(1'b0, 1'b1, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 1'b1, 16'h0910); check(8'hFF, "R7");
        step(1'b0, 1'b0, 1'b1, 16'h0911); check(8'hFF, "R7");

        // R1: reset in the middle of a run
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, 16'h0000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b1, 16'h0911); check(8'h00, "R1");
        step(1'b0, 1'b0, 1'b1, 16'h090F); check(8'h00, "R1");
        step(1'b0, 1'b0, 1'b1, 16'h0910); check(8'h00, "R1");

        finish_run();
    end
endmodule